// File: doc/BRIEF.md
# Configurable serial audio input port

This block takes in audio words from a three-wire serial link made of a bit clock, a data line and a frame sync. It turns each word into a 24-bit parallel sample, left-justified, together with a one-cycle valid strobe and a left/right tag. One configuration byte sets four things: where the word sits relative to the frame sync, how the frame sync marks words, which bit-clock edge captures data, and whether the port makes the bit clock and frame sync itself or follows them from outside.

All pins are sampled in the system clock domain, and bit-clock edges are detected there. In follower mode the external bit clock must therefore be a good deal slower than the system clock. In leader mode the port drives a bit clock at half the system clock rate, with 32 bit clocks per sample. It also drives a matching frame sync and raises an enable so that both pins can be driven off-chip. Capture is double-buffered: the finished sample stays on the output while the next word shifts in. The configuration is expected to stay fixed while reset is released.

Top module: `sai_rx_port`

## Requirements
- R1: While reset is held and just after it is released, `sample_o` is all zeros, and `valid_o` and `right_o` are low.
- R2: The configuration fields sit at fixed bit positions: bit 0 selects the capture edge, bit 1 selects leader mode, bits 3:2 are the frame-sync code and bits 6:4 are the data code. Bit 7 has no effect on any output.
- R3: With bit 0 at 1, data and frame sync are captured on rising bit-clock edges. With bit 0 at 0, they are captured on falling edges.
- R4: In leader mode (bit 1 = 1), `sck_o` toggles on every system clock and `drive_o` is high. In follower mode, `sck_o`, `fs_o` and `drive_o` stay low and `sck_i`/`fs_i` are used instead.
- R5: Frame-sync codes set what starts a word. Code 0 starts a word on a captured low-to-high change of frame sync. Code 1 starts one on a high-to-low change. Codes 2 and 3 start one on any change.
- R6: The bit captured at a word start is the first bit of the new word, and a word ends at the next word start. The first word start after reset opens a word but emits nothing.
- R7: Data code 0, and the unassigned codes 5, 6 and 7, take the first bit as MSB. Words shorter than 24 bits are filled with zeros at the bottom, and bits after the 24th are dropped.
- R8: Data code 1 takes the last bit of the word as LSB. The sample is the last 24 bits received, with zeros above a shorter word.
- R9: Data codes 2, 3 and 4 take the last 16, 18 or 20 bits of the word as the sample's top bits, with zeros below them.
- R10: `valid_o` is high for exactly one system clock for each completed word. `sample_o` and `right_o` change only in that cycle.
- R11: With codes 2 and 3 the tag comes from the frame-sync level at the word start: under code 2 high means left, under code 3 low means left. With codes 0 and 1 the tag alternates, and the first emitted word is left (`right_o` = 0).
- R12: In leader mode the frame sync spans 32 bit clocks per word. Under codes 0 and 1 it is a square wave with a 32-bit period whose active edge is at the word start. Under codes 2 and 3 it holds one level for 32 bits per channel.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_i | input | 8 | Configuration byte |
| sck_i | input | 1 | Bit clock from outside (follower mode) |
| fs_i | input | 1 | Frame sync from outside (follower mode) |
| sd_i | input | 1 | Serial data |
| sck_o | output | 1 | Generated bit clock (leader mode) |
| fs_o | output | 1 | Generated frame sync (leader mode) |
| drive_o | output | 1 | High when sck_o and fs_o are to be driven off-chip |
| sample_o | output | 24 | Held left-justified sample |
| valid_o | output | 1 | One-cycle strobe when sample_o updates |
| right_o | output | 1 | Channel tag of the held sample, 1 = right |

## Verification
A word start does two things on the same capture edge: it closes the old word into the holding register and it takes its own data bit as the first bit of the new word. If these were done in the wrong order, a bit would move between neighbouring samples. The bench sends word lengths that are both shorter and longer than 24 bits, and random pulse or square frame syncs, so the starting bit is always new data. Every emitted sample and tag is compared with a value that the bench rebuilds from the bits it sent itself. Each data change is delayed one system clock after the non-capturing bit-clock edge, so capturing on the wrong edge picks up a stale bit.

// File: rtl/sai_pkg.sv
package sai_pkg;

  // Width of the parallel sample presented at the output.
  parameter int unsigned SAI_W = 24;

  typedef enum logic [2:0] {
    DF_MSB_FIRST = 3'd0,
    DF_MSB_LAST  = 3'd1,
    DF_TAIL16    = 3'd2,
    DF_TAIL18    = 3'd3,
    DF_TAIL20    = 3'd4
  } dfmt_e;

  // Configuration byte; field order is fixed by the register layout.
  typedef struct packed {
    logic       spare;
    logic [2:0] dcode;
    logic [1:0] fscode;
    logic       leader;
    logic       rise_cap;
  } cfg_t;

  // Unassigned codes fall back to MSB-first.
  function automatic dfmt_e decode_dfmt(input logic [2:0] code);
    case (code)
      3'd1:    return DF_MSB_LAST;
      3'd2:    return DF_TAIL16;
      3'd3:    return DF_TAIL18;
      3'd4:    return DF_TAIL20;
      default: return DF_MSB_FIRST;
    endcase
  endfunction

  // Word start test on two consecutive captured frame-sync values.
  function automatic logic is_boundary(input logic [1:0] fscode,
                                       input logic fs_now, input logic fs_prev);
    case (fscode)
      2'd0:    return fs_now & ~fs_prev;
      2'd1:    return ~fs_now & fs_prev;
      default: return fs_now ^ fs_prev;
    endcase
  endfunction

  // Tag of a word that starts now: level-coded or alternating.
  function automatic logic next_tag(input logic [1:0] fscode, input logic fs_now,
                                    input logic open, input logic prev_tag);
    if (fscode[1]) return fscode[0] ? fs_now : ~fs_now;
    return open ? ~prev_tag : 1'b0;
  endfunction

  // Last n received bits moved to the top of the sample.
  function automatic logic [SAI_W-1:0] keep_tail(input logic [SAI_W-1:0] tail,
                                                 input int unsigned n);
    return tail << (SAI_W - n);
  endfunction

  function automatic logic [SAI_W-1:0] form_sample(input dfmt_e f,
                                                   input logic [SAI_W-1:0] head,
                                                   input logic [SAI_W-1:0] tail);
    case (f)
      DF_MSB_LAST: return tail;
      DF_TAIL16:   return keep_tail(tail, 16);
      DF_TAIL18:   return keep_tail(tail, 18);
      DF_TAIL20:   return keep_tail(tail, 20);
      default:     return head;
    endcase
  endfunction

endpackage

// File: rtl/sai_pin_edge.sv
// Samples the serial pins in the system clock domain and finds the
// capturing and launching bit-clock edges.
module sai_pin_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic leader,
  input  logic rise_cap,
  input  logic sck_gen,
  input  logic fs_gen,
  input  logic sck_pin,
  input  logic fs_pin,
  input  logic sd_pin,
  output logic cap_evt,
  output logic launch_evt,
  output logic fs_s,
  output logic sd_s
);

  logic sck_q, fs_q, sd_q, sck_prev, sck_int, rise, fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q    <= 1'b0;
      fs_q     <= 1'b0;
      sd_q     <= 1'b0;
      sck_prev <= 1'b0;
    end else begin
      sck_q    <= sck_pin;
      fs_q     <= fs_pin;
      sd_q     <= sd_pin;
      sck_prev <= sck_int;
    end
  end

  assign sck_int    = leader ? sck_gen : sck_q;
  assign fs_s       = leader ? fs_gen : fs_q;
  assign sd_s       = sd_q;
  assign rise       = sck_int & ~sck_prev;
  assign fall       = ~sck_int & sck_prev;
  assign cap_evt    = rise_cap ? rise : fall;
  assign launch_evt = rise_cap ? fall : rise;

endmodule

// File: rtl/sai_clk_gen.sv
// Leader-mode timing: bit clock at half the system clock, frame sync
// from a bit counter advanced on launching edges.
// BITS_PER_SAMPLE must be a power of two.
module sai_clk_gen #(
  parameter int unsigned BITS_PER_SAMPLE = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] fscode,
  input  logic       launch_evt,
  output logic       sck_gen,
  output logic       fs_gen
);

  localparam int unsigned CNT_W = $clog2(2 * BITS_PER_SAMPLE);

  logic [CNT_W-1:0] cnt;
  logic             phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_gen <= 1'b0;
      cnt     <= '0;
    end else begin
      sck_gen <= ~sck_gen;
      if (launch_evt) cnt <= cnt + 1'b1;
    end
  end

  // Square wave per sample for delineating codes, half-frame level otherwise.
  assign phase  = fscode[1] ? cnt[CNT_W-1] : cnt[CNT_W-2];
  assign fs_gen = phase ^ ~fscode[0];

endmodule

// File: rtl/sai_capture.sv
// Word assembly and the holding register.
module sai_capture import sai_pkg::*; #(
  parameter int unsigned BCNT_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_evt,
  input  logic              fs_s,
  input  logic              sd_s,
  input  logic [2:0]        dcode,
  input  logic [1:0]        fscode,
  output logic [SAI_W-1:0]  sample_o,
  output logic              valid_o,
  output logic              right_o,
  output logic              boundary_evt,
  output logic              word_open,
  output logic [BCNT_W-1:0] bitcnt
);

  localparam logic [BCNT_W-1:0] BCNT_MAX = '1;

  logic             primed, fs_last, tag;
  logic [SAI_W-1:0] head, tail, head_next;
  dfmt_e            dfmt;

  assign dfmt         = decode_dfmt(dcode);
  assign boundary_evt = cap_evt & primed & is_boundary(fscode, fs_last ? fs_s : fs_s, fs_last);

  // Head holds the first SAI_W bits of the word at their MSB-first places.
  always_comb begin
    head_next = head;
    if (int'(bitcnt) < SAI_W)
      head_next = head | ({{(SAI_W-1){1'b0}}, sd_s} << (SAI_W - 1 - int'(bitcnt)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      primed    <= 1'b0;
      fs_last   <= 1'b0;
      tag       <= 1'b0;
      head      <= '0;
      tail      <= '0;
      bitcnt    <= '0;
      word_open <= 1'b0;
      sample_o  <= '0;
      valid_o   <= 1'b0;
      right_o   <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (cap_evt) begin
        primed  <= 1'b1;
        fs_last <= fs_s;
        if (boundary_evt) begin
          if (word_open) begin
            sample_o <= form_sample(dfmt, head, tail);
            right_o  <= tag;
            valid_o  <= 1'b1;
          end
          tag       <= next_tag(fscode, fs_s, word_open, tag);
          word_open <= 1'b1;
          head      <= {sd_s, {(SAI_W-1){1'b0}}};
          tail      <= {{(SAI_W-1){1'b0}}, sd_s};
          bitcnt    <= BCNT_W'(1);
        end else begin
          head <= head_next;
          tail <= {tail[SAI_W-2:0], sd_s};
          if (bitcnt != BCNT_MAX) bitcnt <= bitcnt + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/sai_rx_port.sv
module sai_rx_port import sai_pkg::*; #(
  parameter int unsigned BITS_PER_SAMPLE = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [7:0]       cfg_i,
  input  logic             sck_i,
  input  logic             fs_i,
  input  logic             sd_i,
  output logic             sck_o,
  output logic             fs_o,
  output logic             drive_o,
  output logic [SAI_W-1:0] sample_o,
  output logic             valid_o,
  output logic             right_o
);

  localparam int unsigned BCNT_W = $clog2(2 * BITS_PER_SAMPLE) + 1;

  cfg_t              cfg;
  logic              sck_gen, fs_gen, cap_evt, launch_evt, fs_s, sd_s;
  logic              boundary_evt, word_open;
  logic [BCNT_W-1:0] bitcnt;

  assign cfg = cfg_t'(cfg_i);

  sai_clk_gen #(.BITS_PER_SAMPLE(BITS_PER_SAMPLE)) gen_i (
    .clk(clk), .rst_n(rst_n), .fscode(cfg.fscode), .launch_evt(launch_evt),
    .sck_gen(sck_gen), .fs_gen(fs_gen)
  );

  sai_pin_edge pins_i (
    .clk(clk), .rst_n(rst_n), .leader(cfg.leader), .rise_cap(cfg.rise_cap),
    .sck_gen(sck_gen), .fs_gen(fs_gen), .sck_pin(sck_i), .fs_pin(fs_i), .sd_pin(sd_i),
    .cap_evt(cap_evt), .launch_evt(launch_evt), .fs_s(fs_s), .sd_s(sd_s)
  );

  sai_capture #(.BCNT_W(BCNT_W)) cap_i (
    .clk(clk), .rst_n(rst_n), .cap_evt(cap_evt), .fs_s(fs_s), .sd_s(sd_s),
    .dcode(cfg.dcode), .fscode(cfg.fscode),
    .sample_o(sample_o), .valid_o(valid_o), .right_o(right_o),
    .boundary_evt(boundary_evt), .word_open(word_open), .bitcnt(bitcnt)
  );

  assign sck_o   = cfg.leader & sck_gen;
  assign fs_o    = cfg.leader & fs_gen;
  assign drive_o = cfg.leader;

endmodule

// File: rtl/sai_rx_port_chk.sv
module sai_rx_port_chk #(
  parameter int unsigned BITS_PER_SAMPLE = 32,
  parameter int unsigned BCNT_W = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic [7:0]        cfg_i,
  input logic              sck_i,
  input logic              sck_o,
  input logic              valid_o,
  input logic [23:0]       sample_o,
  input logic              cap_evt,
  input logic              boundary_evt,
  input logic              word_open,
  input logic [BCNT_W-1:0] bitcnt
);

  p_valid_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o);

  p_hold_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_o |-> $stable(sample_o));

  p_emit_after_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> $past(boundary_evt));

  p_capture_edge_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_evt && !cfg_i[1] && $stable(cfg_i)) |-> ($past(sck_i) == cfg_i[0]));

  p_leader_toggle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_i[1] && $past(cfg_i[1]) && $past(rst_n)) |-> (sck_o != $past(sck_o)));

  p_leader_word_len_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_i[1] && $stable(cfg_i) && boundary_evt && word_open)
      |-> (bitcnt == BCNT_W'(BITS_PER_SAMPLE)));

endmodule

bind sai_rx_port sai_rx_port_chk #(.BITS_PER_SAMPLE(BITS_PER_SAMPLE), .BCNT_W(BCNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .cfg_i(cfg_i), .sck_i(sck_i), .sck_o(sck_o),
  .valid_o(valid_o), .sample_o(sample_o), .cap_evt(cap_evt),
  .boundary_evt(boundary_evt), .word_open(word_open), .bitcnt(bitcnt)
);

// File: tb/sai_rx_port_tb_top.sv
module sai_rx_port_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  cfg = 8'h00;
  logic        sck_i = 1'b0, fs_i = 1'b0, sd_i = 1'b0;
  logic        sck_o, fs_o, drive_o, valid_o, right_o;
  logic [23:0] sample_o;

  int n_chk = 0, n_bad = 0;

  logic [23:0] exp_q[$];
  logic        exp_r_q[$];
  int          words_got = 0, words_exp = 0;
  bit          m_primed, m_fsp, m_open, m_tag;
  bit [63:0]   wb;
  int          wlen;
  bit          held_bad;
  logic [23:0] last_sample;

  always #2 clk = ~clk;

  sai_rx_port dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_i(cfg), .sck_i(sck_i), .fs_i(fs_i), .sd_i(sd_i),
    .sck_o(sck_o), .fs_o(fs_o), .drive_o(drive_o),
    .sample_o(sample_o), .valid_o(valid_o), .right_o(right_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic string req_of(input logic [2:0] code);
    case (code)
      3'd1: return "R8";
      3'd2, 3'd3, 3'd4: return "R9";
      default: return "R7";
    endcase
  endfunction

  // Expected sample rebuilt from the list of bits sent, first bit at index 0.
  function automatic logic [23:0] exp_sample(input logic [2:0] code, input bit [63:0] bits,
                                             input int len);
    logic [23:0] r;
    int n;
    r = '0;
    case (code)
      3'd1: n = 24;
      3'd2: n = 16;
      3'd3: n = 18;
      3'd4: n = 20;
      default: n = 0;
    endcase
    if (n == 0) begin
      for (int i = 0; i < 24; i++) if (i < len) r[23-i] = bits[i];
    end else begin
      for (int i = 0; i < n; i++) if (len - 1 - i >= 0) r[24-n+i] = bits[len-1-i];
    end
    return r;
  endfunction

  // Bench view of one captured (frame sync, data) pair.
  task automatic model_bit(input bit fs, input bit d);
    bit bnd;
    case (cfg[3:2])
      2'd0: bnd = fs && !m_fsp;
      2'd1: bnd = !fs && m_fsp;
      default: bnd = (fs != m_fsp);
    endcase
    if (m_primed && bnd) begin
      if (m_open) begin
        exp_q.push_back(exp_sample(cfg[6:4], wb, wlen));
        exp_r_q.push_back(m_tag);
        words_exp++;
        if (cfg[1]) chk(wlen == 32, "R12", "leader word length", wlen, 32);
      end
      if (cfg[3]) m_tag = cfg[2] ? fs : !fs;
      else m_tag = m_open ? !m_tag : 1'b0;
      m_open = 1'b1;
      wb = '0;
      wb[0] = d;
      wlen = 1;
    end else if (m_open && wlen < 64) begin
      wb[wlen] = d;
      wlen++;
    end
    m_primed = 1'b1;
    m_fsp = fs;
  endtask

  always @(negedge clk) begin
    if (!rst_n) begin
      last_sample <= '0;
      held_bad <= 1'b0;
    end else if (valid_o) begin
      words_got++;
      if (exp_q.size() == 0) begin
        chk(1'b0, "R6", "unexpected word", sample_o, 0);
      end else begin
        logic [23:0] es;
        logic er;
        es = exp_q.pop_front();
        er = exp_r_q.pop_front();
        chk(sample_o == es, $sformatf("%s R3%s", req_of(cfg[6:4]), cfg[7] ? " R2" : ""),
            "sample", sample_o, es);
        chk(right_o == er, "R11", "tag", right_o, er);
      end
      chk(!held_bad, "R10", "output moved without strobe", held_bad, 0);
      held_bad <= 1'b0;
      last_sample <= sample_o;
    end else if (sample_o != last_sample) begin
      held_bad <= 1'b1;
    end
  end

  task automatic apply_reset(input logic [7:0] c);
    rst_n = 1'b0;
    cfg = c;
    sck_i = c[0] ? 1'b0 : 1'b1;
    fs_i = 1'b0;
    sd_i = 1'b0;
    exp_q.delete();
    exp_r_q.delete();
    words_got = 0;
    words_exp = 0;
    m_primed = 0; m_fsp = 0; m_open = 0; m_tag = 0; wlen = 0; wb = '0;
    repeat (4) @(negedge clk);
    chk(sample_o == 24'h0 && !valid_o && !right_o, "R1", "reset outputs",
        {sample_o, 6'b0, valid_o, right_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(sample_o == 24'h0 && !valid_o, "R1", "after release", {sample_o, 7'b0, valid_o}, 0);
  endtask

  task automatic end_run();
    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R5", "words left unseen", exp_q.size(), 0);
    chk(words_got == words_exp, "R6", "word count", words_got, words_exp);
  endtask

  task automatic send_bit(input bit fs, input bit d);
    sck_i = cfg[0] ? 1'b0 : 1'b1;
    @(negedge clk);
    fs_i = fs;
    sd_i = d;
    repeat (2) @(negedge clk);
    sck_i = cfg[0];
    model_bit(fs, d);
    repeat (3) @(negedge clk);
  endtask

  task automatic run_follower(input logic [7:0] c, input int fixed_len, input int nwords);
    bit pulse, fsv, right;
    int len;
    bit quiet;
    apply_reset(c);
    pulse = 1'($urandom);
    quiet = 1'b1;
    for (int k = 0; k < 3; k++) begin
      case (c[3:2])
        2'd0: fsv = 1'b0;
        2'd1: fsv = 1'b1;
        2'd2: fsv = 1'b0;
        default: fsv = 1'b1;
      endcase
      send_bit(fsv, 1'($urandom));
    end
    for (int w = 0; w <= nwords; w++) begin
      len = (fixed_len != 0) ? fixed_len : 16 + int'($urandom % 17);
      right = w[0];
      for (int b = 0; b < len; b++) begin
        case (c[3:2])
          2'd0: fsv = pulse ? (b == 0) : (b < len / 2);
          2'd1: fsv = pulse ? (b != 0) : (b >= len / 2);
          2'd2: fsv = !right;
          default: fsv = right;
        endcase
        send_bit(fsv, 1'($urandom));
        if (sck_o || fs_o || drive_o) quiet = 1'b0;
      end
    end
    chk(quiet, "R4", "follower outputs quiet", quiet, 1);
    end_run();
  endtask

  task automatic run_leader(input logic [7:0] c, input int nclk);
    logic prev;
    bit tog_ok;
    apply_reset(c);
    prev = sck_o;
    tog_ok = 1'b1;
    for (int k = 0; k < nclk; k++) begin
      @(negedge clk);
      if (sck_o == prev) tog_ok = 1'b0;
      else if (sck_o == c[0]) model_bit(fs_o, sd_i);
      else sd_i = 1'($urandom);
      prev = sck_o;
    end
    chk(tog_ok, "R4", "leader clock toggles every cycle", tog_ok, 1);
    chk(drive_o, "R4", "leader drive enable", drive_o, 1);
    end_run();
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    chk(1'b0, "R6", "watchdog expired", 0, 1);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] c;
    void'($urandom(32'd20240611));
    // Directed: short and long MSB-first words, short right-justified, 20-bit tail.
    run_follower(8'h00, 16, 4);
    run_follower(8'h05, 30, 4);
    run_follower(8'h14, 16, 4);
    run_follower(8'hC9, 20, 4);
    // Random sweep over data codes including the unassigned ones.
    for (int i = 0; i < 16; i++) begin
      c = {1'($urandom), 3'(i % 8), 2'((i + i / 8) % 4), 1'b0, 1'($urandom)};
      run_follower(c, 0, 8);
    end
    // Leader mode across all frame-sync codes.
    for (int i = 0; i < 4; i++) begin
      c = {1'($urandom), 3'((i * 3) % 5), 2'(i), 1'b1, 1'(i % 2)};
      run_leader(c, 64 * 2 * 5);
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule